// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the device side of an in-system programming link. An external programmer drives a serial clock and a data line into the chip. The block takes both lines into the system clock domain and assembles the bits into fixed frames of four bytes. It returns bytes on a serial output line, and it turns each decoded frame into a single-cycle command strobe for a memory back-end. The back-end supports four actions: loading one byte into a page buffer, committing that page, writing one byte of the non-volatile data store, and reading a byte.

Commands take effect only after the link has been opened by an unlock frame. Every byte the programmer sends is shifted back one byte later. This lets the programmer confirm that it is aligned to frame boundaries by watching the second unlock byte come back while it sends the third byte. A session input clears all framing and unlock state while it is low. A busy flag from the back-end blocks every command that would modify memory. Reads still run while busy, so the programmer can poll a location until it holds its final value.

Top module: `isp_target`

## Requirements
- R1: After system reset, `miso` is 0, no strobe is asserted and the link is locked.
- R2: `mosi` is sampled when a rising `sck` edge is detected after synchronization, and bytes arrive MSB first. `sck` high and low phases each last at least two system clocks.
- R3: `miso` changes only in response to a falling `sck` edge, within three system clocks of it. Each output byte is sent MSB first and stays stable through the high phase of its bit.
- R4: Every frame is exactly four bytes long, and the byte counter returns to the first byte after the fourth byte.
- R5: A frame whose first byte is 0xAC and whose second byte is 0x53 unlocks the link. A locked link ignores a frame with any other first byte, or with another second byte.
- R6: While the link is locked, no frame produces a strobe.
- R7: During byte 0 of a frame `miso` sends 0x00. During bytes 1 and 2 it sends the previous byte of the same frame. During byte 3 it sends byte 2, unless the frame is a read.
- R8: Read opcodes are 0x20 (low half of the program store), 0x28 (high half, `high_byte`=1) and 0x50 (data store, `eeprom_sel`=1). When the third byte has been received, `read_stb` pulses with `addr`={byte1,byte2}. The `rdata` present one clock later is sent on `miso` as byte 3.
- R9: Opcodes 0x10 and 0x18 pulse `load_stb` after the fourth byte, with `addr`={byte1,byte2}, `wdata`=byte3 and `high_byte` equal to opcode bit 3.
- R10: Opcode 0x30 pulses `commit_stb` with `addr`={byte1,byte2}. Opcode 0x60 pulses `ee_write_stb` with `addr`={byte1,byte2}, `wdata`=byte3 and `eeprom_sel`=1. Other opcodes produce no strobe.
- R11: When `mem_busy` is high as the fourth byte completes, no load, commit or data-store write strobe is produced. Reads are still serviced while busy.
- R12: While `prog_active` is low, the bit counter, the byte counter, the unlock state and `miso` are held at zero, and `sck` edges are ignored.
- R13: At most one strobe is high in any cycle, each strobe lasts one cycle, and an unlocked frame yields at most one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_active | input | 1 | Session enable; low clears framing and unlock state |
| sck | input | 1 | Serial clock from the programmer (asynchronous) |
| mosi | input | 1 | Serial data from the programmer (asynchronous) |
| miso | output | 1 | Serial data to the programmer |
| mem_busy | input | 1 | Back-end is still completing a write |
| rdata | input | 8 | Read data, valid one clock after `read_stb` |
| load_stb | output | 1 | Load one byte into the page buffer |
| commit_stb | output | 1 | Commit the page buffer |
| read_stb | output | 1 | Read request |
| ee_write_stb | output | 1 | Data-store byte write |
| addr | output | 16 | Address for the current strobe |
| wdata | output | 8 | Write data for load and data-store write |
| high_byte | output | 1 | Selects the high half of a program word |
| eeprom_sel | output | 1 | Selects the data store rather than the program store |

## Verification
The hardest case to reach is a read at the fastest allowed `sck` rate. There the back-end's reply has to reach the output shifter on the same falling edge that starts byte 3, so only a couple of clocks separate the strobe from the load. The bench runs a dedicated read frame with two-clock `sck` phases and checks that the memory value still comes back. A second hard case is a session dropped in the middle of a frame. The bench stops after two bytes, pulses `prog_active`, and then checks that a fresh unlock followed by a load lands on the correct frame boundary.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int SYNC_DEPTH  = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Frame opcodes (first byte) and the unlock key (second byte)
    localparam byte_t OP_UNLOCK   = 8'hAC;
    localparam byte_t UNLOCK_KEY  = 8'h53;
    localparam byte_t OP_LOAD_LO  = 8'h10;
    localparam byte_t OP_LOAD_HI  = 8'h18;
    localparam byte_t OP_COMMIT   = 8'h30;
    localparam byte_t OP_READ_LO  = 8'h20;
    localparam byte_t OP_READ_HI  = 8'h28;
    localparam byte_t OP_READ_EE  = 8'h50;
    localparam byte_t OP_EE_WRITE = 8'h60;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_COMMIT = 3'd2,
        ACT_READ   = 3'd3,
        ACT_EEWR   = 3'd4
    } act_e;

    function automatic act_e classify(input byte_t op);
        act_e a;
        case (op)
            OP_LOAD_LO, OP_LOAD_HI:             a = ACT_LOAD;
            OP_COMMIT:                          a = ACT_COMMIT;
            OP_READ_LO, OP_READ_HI, OP_READ_EE: a = ACT_READ;
            OP_EE_WRITE:                        a = ACT_EEWR;
            default:                            a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/isp_sync_edge.sv
module isp_sync_edge #(
    parameter int STAGES = isp_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic mosi_o
);
    localparam int SCK_LEN  = STAGES + 1;   // one extra stage keeps the previous level
    localparam int DATA_LEN = STAGES;

    typedef struct packed {
        logic [SCK_LEN-1:0]  sck;
        logic [DATA_LEN-1:0] dat;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.sck = {sync_q.sck[SCK_LEN-2:0], sck_i};
        sync_d.dat = {sync_q.dat[DATA_LEN-2:0], mosi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.sck[STAGES-1] & ~sync_q.sck[STAGES];
    assign fall_o = ~sync_q.sck[STAGES-1] & sync_q.sck[STAGES];
    assign mosi_o = sync_q.dat[DATA_LEN-1];

    // R2: a detected rising edge cannot repeat on the next cycle
    p_rise_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int BYTE_W      = isp_pkg::BYTE_W,
    parameter int FRAME_BYTES = isp_pkg::FRAME_BYTES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           active_i,
    input  logic                           rise_i,
    input  logic                           fall_i,
    input  logic                           mosi_i,
    input  logic [BYTE_W-1:0]              tx_data_i,
    output logic                           done_o,
    output logic [$clog2(FRAME_BYTES)-1:0] done_idx_o,
    output logic [BYTE_W-1:0]              done_byte_o,
    output logic [$clog2(FRAME_BYTES)-1:0] cur_idx_o,
    output logic                           miso_o
);
    localparam int IDX_W    = $clog2(FRAME_BYTES);
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int LAST_BIT = BYTE_W - 1;
    localparam int LAST_IDX = FRAME_BYTES - 1;

    typedef struct packed {
        logic [BIT_W-1:0]  bit_cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } shf_t;

    shf_t shf_d, shf_q;
    logic last_bit;
    logic last_idx;

    assign last_bit = (shf_q.bit_cnt == BIT_W'(LAST_BIT));
    assign last_idx = (shf_q.idx == IDX_W'(LAST_IDX));

    always_comb begin
        shf_d = shf_q;
        if (!active_i) begin
            shf_d = '0;
        end else begin
            if (rise_i) begin
                shf_d.rx = {shf_q.rx[BYTE_W-2:0], mosi_i};
                if (last_bit) begin
                    shf_d.bit_cnt = '0;
                    shf_d.idx     = last_idx ? '0 : shf_q.idx + 1'b1;
                end else begin
                    shf_d.bit_cnt = shf_q.bit_cnt + 1'b1;
                end
            end
            if (fall_i) begin
                if (shf_q.bit_cnt == '0) shf_d.tx = tx_data_i;
                else                     shf_d.tx = {shf_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign done_o      = active_i & rise_i & last_bit;
    assign done_idx_o  = shf_q.idx;
    assign done_byte_o = {shf_q.rx[BYTE_W-2:0], mosi_i};
    assign cur_idx_o   = shf_q.idx;
    assign miso_o      = shf_q.tx[BYTE_W-1];

    // R3: the output only moves after a falling edge
    p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !fall_i) |=> $stable(miso_o));

    // R4: the fourth byte returns the counter to byte 0
    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_idx_o == IDX_W'(LAST_IDX)) |=> (cur_idx_o == '0));

    // R2: bit counting advances only on a detected rising edge
    p_count_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !rise_i) |=> $stable(shf_q.bit_cnt));

    // R12: an inactive session leaves framing and output at zero
    p_idle_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (cur_idx_o == '0 && !miso_o));

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int BYTE_W      = isp_pkg::BYTE_W,
    parameter int FRAME_BYTES = isp_pkg::FRAME_BYTES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           active_i,
    input  logic                           done_i,
    input  logic [$clog2(FRAME_BYTES)-1:0] done_idx_i,
    input  logic [BYTE_W-1:0]              done_byte_i,
    input  logic [$clog2(FRAME_BYTES)-1:0] cur_idx_i,
    input  logic                           busy_i,
    input  logic [BYTE_W-1:0]              rdata_i,
    output logic [BYTE_W-1:0]              tx_data_o,
    output logic                           load_o,
    output logic                           commit_o,
    output logic                           read_o,
    output logic                           ee_write_o,
    output logic [2*BYTE_W-1:0]            addr_o,
    output logic [BYTE_W-1:0]              wdata_o,
    output logic                           hi_o,
    output logic                           ee_sel_o
);
    localparam int IDX_W    = $clog2(FRAME_BYTES);
    localparam int HDR_N    = FRAME_BYTES - 1;  // bytes kept before the last one
    localparam int LAST_IDX = FRAME_BYTES - 1;
    localparam int POS_OP   = 0;
    localparam int POS_AHI  = 1;
    localparam int POS_ALO  = 2;
    localparam int ADDR_W   = 2 * BYTE_W;
    localparam int HI_BIT   = 3;                // opcode bit that picks the high half

    typedef struct packed {
        logic [HDR_N-1:0][BYTE_W-1:0] hdr;
        logic                         unlocked;
        logic                         rd_frame;
        logic                         load;
        logic                         commit;
        logic                         read;
        logic                         eewr;
        logic [ADDR_W-1:0]            addr;
        logic [BYTE_W-1:0]            wdata;
        logic                         hi;
        logic                         ee_sel;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    byte_t op;
    act_e  kind;
    logic  at_last;
    logic  at_alo;

    assign op      = ctl_q.hdr[POS_OP];
    assign kind    = classify(op);
    assign at_last = (done_idx_i == IDX_W'(LAST_IDX));
    assign at_alo  = (done_idx_i == IDX_W'(POS_ALO));

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.load   = 1'b0;
        ctl_d.commit = 1'b0;
        ctl_d.read   = 1'b0;
        ctl_d.eewr   = 1'b0;
        if (!active_i) begin
            ctl_d.unlocked = 1'b0;
            ctl_d.rd_frame = 1'b0;
        end else if (done_i) begin
            for (int k = 0; k < HDR_N; k++) begin
                if (done_idx_i == IDX_W'(k)) ctl_d.hdr[k] = done_byte_i;
            end
            // reads launch early so the reply is ready for the last byte
            if (at_alo && ctl_q.unlocked && kind == ACT_READ) begin
                ctl_d.read     = 1'b1;
                ctl_d.rd_frame = 1'b1;
                ctl_d.addr     = {ctl_q.hdr[POS_AHI], done_byte_i};
                ctl_d.hi       = op[HI_BIT];
                ctl_d.ee_sel   = (op == OP_READ_EE);
            end
            if (at_last) begin
                ctl_d.rd_frame = 1'b0;
                if (!ctl_q.unlocked) begin
                    if (op == OP_UNLOCK && ctl_q.hdr[POS_AHI] == UNLOCK_KEY)
                        ctl_d.unlocked = 1'b1;
                end else if (!busy_i) begin
                    case (kind)
                        ACT_LOAD: begin
                            ctl_d.load   = 1'b1;
                            ctl_d.addr   = {ctl_q.hdr[POS_AHI], ctl_q.hdr[POS_ALO]};
                            ctl_d.wdata  = done_byte_i;
                            ctl_d.hi     = op[HI_BIT];
                            ctl_d.ee_sel = 1'b0;
                        end
                        ACT_COMMIT: begin
                            ctl_d.commit = 1'b1;
                            ctl_d.addr   = {ctl_q.hdr[POS_AHI], ctl_q.hdr[POS_ALO]};
                            ctl_d.ee_sel = 1'b0;
                        end
                        ACT_EEWR: begin
                            ctl_d.eewr   = 1'b1;
                            ctl_d.addr   = {ctl_q.hdr[POS_AHI], ctl_q.hdr[POS_ALO]};
                            ctl_d.wdata  = done_byte_i;
                            ctl_d.ee_sel = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Byte handed to the shifter: 0 at frame start, then a one-byte echo
    always_comb begin
        tx_data_o = '0;
        for (int k = 1; k <= LAST_IDX; k++) begin
            if (cur_idx_i == IDX_W'(k)) tx_data_o = ctl_q.hdr[k-1];
        end
        if (cur_idx_i == IDX_W'(LAST_IDX) && ctl_q.rd_frame) tx_data_o = rdata_i;
    end

    assign load_o     = ctl_q.load;
    assign commit_o   = ctl_q.commit;
    assign read_o     = ctl_q.read;
    assign ee_write_o = ctl_q.eewr;
    assign addr_o     = ctl_q.addr;
    assign wdata_o    = ctl_q.wdata;
    assign hi_o       = ctl_q.hi;
    assign ee_sel_o   = ctl_q.ee_sel;

    // R6: a locked link emits nothing
    p_locked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.unlocked |=> !(load_o || commit_o || read_o || ee_write_o));

    // R13: strobes are mutually exclusive
    p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, commit_o, read_o, ee_write_o}));

    // R13: strobes last a single cycle
    p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o || commit_o || read_o || ee_write_o) |=>
        !(load_o || commit_o || read_o || ee_write_o));

    // R11: busy at frame end blocks every modifying strobe
    p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && done_i && at_last && busy_i) |=> !(load_o || commit_o || ee_write_o));

    // R5: a locked frame with a foreign opcode keeps the link locked
    p_stay_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && at_last && !ctl_q.unlocked && op != OP_UNLOCK) |=> !ctl_q.unlocked);

endmodule

// File: rtl/isp_target.sv
module isp_target (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_active,
    input  logic        sck,
    input  logic        mosi,
    output logic        miso,
    input  logic        mem_busy,
    input  logic [7:0]  rdata,
    output logic        load_stb,
    output logic        commit_stb,
    output logic        read_stb,
    output logic        ee_write_stb,
    output logic [15:0] addr,
    output logic [7:0]  wdata,
    output logic        high_byte,
    output logic        eeprom_sel
);
    localparam int BYTE_W = isp_pkg::BYTE_W;
    localparam int FRAMEB = isp_pkg::FRAME_BYTES;
    localparam int IDX_W  = $clog2(FRAMEB);

    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic              byte_done;
    logic [IDX_W-1:0]  done_idx;
    logic [BYTE_W-1:0] done_byte;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] tx_byte;

    isp_sync_edge #(.STAGES(isp_pkg::SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck),
        .mosi_i (mosi),
        .rise_o (sck_rise),
        .fall_o (sck_fall),
        .mosi_o (mosi_s)
    );

    isp_shifter #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAMEB)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (prog_active),
        .rise_i      (sck_rise),
        .fall_i      (sck_fall),
        .mosi_i      (mosi_s),
        .tx_data_i   (tx_byte),
        .done_o      (byte_done),
        .done_idx_o  (done_idx),
        .done_byte_o (done_byte),
        .cur_idx_o   (cur_idx),
        .miso_o      (miso)
    );

    isp_ctrl #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAMEB)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (prog_active),
        .done_i      (byte_done),
        .done_idx_i  (done_idx),
        .done_byte_i (done_byte),
        .cur_idx_i   (cur_idx),
        .busy_i      (mem_busy),
        .rdata_i     (rdata),
        .tx_data_o   (tx_byte),
        .load_o      (load_stb),
        .commit_o    (commit_stb),
        .read_o      (read_stb),
        .ee_write_o  (ee_write_stb),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .hi_o        (high_byte),
        .ee_sel_o    (eeprom_sel)
    );

endmodule

// File: tb/isp_target_bench.sv
`timescale 1ns/1ps
module isp_target_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_active = 1'b0;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic        mem_busy = 1'b0;
    logic [7:0]  rdata = 8'h00;
    logic        load_stb, commit_stb, read_stb, ee_write_stb;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        high_byte, eeprom_sel;

    always #2 clk = ~clk;   // 250 MHz

    isp_target u_isp_target (
        .clk(clk), .rst_n(rst_n), .prog_active(prog_active), .sck(sck), .mosi(mosi),
        .miso(miso), .mem_busy(mem_busy), .rdata(rdata), .load_stb(load_stb),
        .commit_stb(commit_stb), .read_stb(read_stb), .ee_write_stb(ee_write_stb),
        .addr(addr), .wdata(wdata), .high_byte(high_byte), .eeprom_sel(eeprom_sel)
    );

    int tests = 0;
    int fails = 0;
    int half = 4;
    int cycles = 0;
    bit finished = 1'b0;

    // strobe monitor (counts only grow; tests compare deltas)
    int n_load = 0, n_commit = 0, n_read = 0, n_ee = 0;
    logic [15:0] cap_addr = '0;
    logic [7:0]  cap_wdata = '0;
    logic        cap_hi = 1'b0, cap_ee = 1'b0;

    function automatic logic [7:0] mem_val(input logic [15:0] a, input logic hi, input logic ee);
        return a[7:0] ^ a[15:8] ^ (hi ? 8'h0F : 8'h00) ^ (ee ? 8'hF0 : 8'h00);
    endfunction

    // behavioural back-end: one clock of read latency
    always @(posedge clk) if (read_stb) rdata <= mem_val(addr, high_byte, eeprom_sel);

    always @(negedge clk) begin
        if (load_stb)     n_load++;
        if (commit_stb)   n_commit++;
        if (read_stb)     n_read++;
        if (ee_write_stb) n_ee++;
        if (load_stb || commit_stb || read_stb || ee_write_stb) begin
            cap_addr = addr; cap_wdata = wdata; cap_hi = high_byte; cap_ee = eeprom_sel;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (half) @(negedge clk);
            sck = 1'b1;
            repeat (half) @(negedge clk);
            got[i] = miso;      // end of high phase
            sck = 1'b0;
        end
    endtask

    task automatic xfer_frame(input logic [31:0] f, output logic [31:0] got);
        logic [7:0] g;
        for (int k = 0; k < 4; k++) begin
            xfer_byte(f[31-8*k -: 8], g);
            got[31-8*k -: 8] = g;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic session_pulse();
        prog_active = 1'b0;
        repeat (4) @(negedge clk);
        prog_active = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic int total_strobes();
        return n_load + n_commit + n_read + n_ee;
    endfunction

    // {b0,b1,b2,b3,busy,kind}; kind 0 none 1 load 2 commit 3 read 4 ee-write
    localparam logic [35:0] VECS [0:14] = '{
        {8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 3'd0},   // locked, foreign frame (R6)
        {8'h10, 8'h01, 8'h02, 8'hAA, 1'b0, 3'd0},   // locked, load ignored (R6)
        {8'hAC, 8'h53, 8'h00, 8'h00, 1'b0, 3'd0},   // unlock (R5)
        {8'h10, 8'h01, 8'h23, 8'h5A, 1'b0, 3'd1},   // load low (R9)
        {8'h18, 8'h01, 8'h23, 8'hA5, 1'b0, 3'd1},   // load high (R9)
        {8'h30, 8'h01, 8'h20, 8'h00, 1'b0, 3'd2},   // commit (R10)
        {8'h60, 8'h00, 8'h7F, 8'hC3, 1'b0, 3'd4},   // data-store write (R10)
        {8'h20, 8'h12, 8'h34, 8'h00, 1'b0, 3'd3},   // read low (R8)
        {8'h28, 8'h12, 8'h34, 8'h00, 1'b0, 3'd3},   // read high (R8)
        {8'h50, 8'h00, 8'h10, 8'h00, 1'b0, 3'd3},   // read data store (R8)
        {8'h10, 8'h00, 8'h05, 8'h11, 1'b1, 3'd0},   // busy load blocked (R11)
        {8'h30, 8'h00, 8'h00, 8'h00, 1'b1, 3'd0},   // busy commit blocked (R11)
        {8'h20, 8'hAB, 8'hCD, 8'h00, 1'b1, 3'd3},   // busy read serviced (R11)
        {8'h99, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0},   // unknown opcode (R10)
        {8'hAC, 8'h53, 8'h00, 8'h00, 1'b0, 3'd0}    // unlock while open: no strobe (R13)
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [7:0]  b0, b1, b2, b3, exp3, gb;
        logic [2:0]  kind;
        int s_load, s_commit, s_read, s_ee, s_tot;

        repeat (3) @(negedge clk);
        check(miso == 1'b0, "R1 miso in reset", miso, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(miso == 1'b0 && total_strobes() == 0, "R1 idle after reset", miso, 0);
        prog_active = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < 15; v++) begin
            {b0, b1, b2, b3} = VECS[v][35:4];
            mem_busy = VECS[v][3];
            kind     = VECS[v][2:0];
            s_load = n_load; s_commit = n_commit; s_read = n_read; s_ee = n_ee;
            s_tot  = total_strobes();
            xfer_frame({b0, b1, b2, b3}, got);
            mem_busy = 1'b0;
            exp3 = (kind == 3'd3) ? mem_val({b1, b2}, b0[3], b0 == 8'h50) : b2;
            check(got[31:24] == 8'h00, "R7 byte0 zero", got[31:24], 8'h00);
            check(got[23:16] == b0, "R7 R3 echo byte1", got[23:16], b0);
            check(got[15:8] == b1, "R7 R5 echo byte2", got[15:8], b1);
            check(got[7:0] == exp3, "R7 R8 byte3", got[7:0], exp3);
            case (kind)
                3'd0: check(total_strobes() == s_tot, "R6 R11 R10 no strobe", total_strobes() - s_tot, 0);
                3'd1: check(n_load - s_load == 1 && total_strobes() - s_tot == 1, "R9 R13 load once", n_load - s_load, 1);
                3'd2: check(n_commit - s_commit == 1 && total_strobes() - s_tot == 1, "R10 R13 commit once", n_commit - s_commit, 1);
                3'd3: check(n_read - s_read == 1 && total_strobes() - s_tot == 1, "R8 R13 read once", n_read - s_read, 1);
                default: check(n_ee - s_ee == 1 && total_strobes() - s_tot == 1, "R10 R13 ee once", n_ee - s_ee, 1);
            endcase
            if (kind != 3'd0)
                check(cap_addr == {b1, b2}, "R8 R9 R10 address", cap_addr, {b1, b2});
            if (kind == 3'd1 || kind == 3'd4)
                check(cap_wdata == b3, "R9 R10 write data", cap_wdata, b3);
            if (kind == 3'd1 || kind == 3'd3)
                check(cap_hi == b0[3], "R8 R9 high select", cap_hi, b0[3]);
            if (kind != 3'd0)
                check(cap_ee == (kind == 3'd4 || b0 == 8'h50), "R8 R10 store select", cap_ee,
                      (kind == 3'd4 || b0 == 8'h50));
        end

        // R12: dropping the session relocks the link
        session_pulse();
        s_tot = total_strobes();
        xfer_frame({8'h10, 8'h00, 8'h01, 8'h55}, got);
        check(total_strobes() == s_tot, "R12 relocked after session drop", total_strobes() - s_tot, 0);

        // R5: wrong key keeps the link locked
        xfer_frame({8'hAC, 8'h00, 8'h00, 8'h00}, got);
        check(got[15:8] == 8'h00, "R7 echo of wrong key", got[15:8], 8'h00);
        xfer_frame({8'h10, 8'h00, 8'h01, 8'h55}, got);
        check(total_strobes() == s_tot, "R5 wrong key stays locked", total_strobes() - s_tot, 0);

        // R12 R4: abort mid-frame, then realign
        xfer_frame({8'hAC, 8'h53, 8'h00, 8'h00}, got);
        xfer_byte(8'h10, gb);
        xfer_byte(8'h07, gb);
        prog_active = 1'b0;
        repeat (4) @(negedge clk);
        check(miso == 1'b0, "R12 miso cleared", miso, 0);
        prog_active = 1'b1;
        repeat (4) @(negedge clk);
        xfer_frame({8'hAC, 8'h53, 8'h00, 8'h00}, got);
        check(got[23:16] == 8'hAC && got[15:8] == 8'h53, "R4 R5 realigned echo", got[23:8], 16'hAC53);
        s_load = n_load;
        xfer_frame({8'h18, 8'h3C, 8'hC3, 8'h99}, got);
        check(n_load - s_load == 1 && cap_addr == 16'h3CC3 && cap_wdata == 8'h99,
              "R4 load after realign", cap_addr, 16'h3CC3);

        // R2 R8: fastest sck, read data still returned
        half = 2;
        xfer_frame({8'h28, 8'h55, 8'hAA, 8'h00}, got);
        check(got[7:0] == mem_val(16'h55AA, 1'b1, 1'b0), "R2 R8 fast read", got[7:0],
              mem_val(16'h55AA, 1'b1, 1'b0));
        check(got[23:16] == 8'h28, "R3 fast echo", got[23:16], 8'h28);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule